// File: doc/BRIEF.md
# Flash March Command Sequencer

This block is the sequencing core of a self-test engine for a flash array. It steps through a march algorithm one element at a time. Each element is a 5-bit command. The block decodes the command into a short tuple of flash operations: whole-array erase, program-to-zero, and read with an expected value. It applies that tuple at every address in the chosen direction. Each operation goes to the memory as a held request and completes when the memory returns a ready pulse. The memory model therefore sets the program and erase latency.

Three modes select where the elements come from. Test mode plays a fixed six-element algorithm from an internal table. Diagnosis mode plays a user algorithm that was shifted in bit-serially beforehand. Burn-in mode loops over a fixed eight-pass read pattern for as long as it stays enabled. Every read is compared against its expected value. A mismatch produces a single-cycle error strobe carrying the address, the XOR syndrome and the element index.

Top module: `flash_march_seq`

## Requirements
- R1: After reset the block is idle: no operation request, done low, error strobe low.
- R2: A command's bits 4..2 select the tuple, bit 1 (B) is the data background and bit 0 (D) the direction. The tuples are: 000 read(B); 001 read(B),program; 010 read(B),program,read0; 011 read(B),program,read0,read0; 101 program,read0; 110 program; 100 erase; 111 ends the algorithm.
- R3: With D=1 an element visits addresses 0 up to the top address. With D=0 it visits them from the top address down to 0. The whole tuple is applied at one address before the next address is visited.
- R4: A read expects all ones when B=1 and all zeros otherwise (read0 steps always expect zeros). A mismatch raises err_o for exactly one cycle, with err_addr_o, err_syn_o = data XOR expected, and err_elem_o = index of the element (from 0).
- R5: An erase element issues exactly one erase request, at address 0, regardless of the address count.
- R6: In test mode (mode_i=0) the element order is: erase; ascending read1,program,read0; ascending read0; erase; descending read1,program,read0; descending read0. The block then raises done_o and holds it.
- R7: In diagnosis mode (mode_i=1) the commands are shifted in MSB first, 5 bits per command, on cycles with shift_en_i high. They then run in load order until the end command, after which done_o is raised.
- R8: The buffer holds DEPTH commands. Bits shifted in after it is full are ignored. Any slot not loaded, and any index past DEPTH, acts as the end command.
- R9: In burn-in mode (mode_i=2) the passes are read-only, in this order: up r1, up r0, down r1, down r0, up r1, down r0, down r1, up r0. done_o rises after the first full round, and the passes then repeat.
- R10: op_kind_o encodes read=0, program=1, erase=2. A request stays high, with stable kind and address, until op_rdy_i is seen. It is low in the cycle after ready.
- R11: Lowering run_en_i returns the block to idle in one cycle, with request and done_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en_i | input | 1 | Start on rise, abort when low |
| mode_i | input | 2 | 0 test, 1 diagnosis, 2 burn-in |
| shift_en_i | input | 1 | Serial command bit valid |
| shift_bit_i | input | 1 | Serial command bit, MSB first |
| op_req_o | output | 1 | Flash operation request |
| op_kind_o | output | 2 | Operation kind |
| op_addr_o | output | AW | Operation address |
| op_rdy_i | input | 1 | Operation complete pulse |
| rd_data_i | input | DW | Read data, valid with op_rdy_i |
| err_o | output | 1 | Mismatch strobe |
| err_addr_o | output | AW | Faulty address |
| err_syn_o | output | DW | Error syndrome |
| err_elem_o | output | IW | Index of the failing element |
| done_o | output | 1 | Algorithm finished |

## Verification
The operation stream is logged at the memory model. It is compared entry by entry against a stream built independently from the command table. This exposes wrong tuples, wrong direction, per-address erase and misordered elements.

A fault-free array separates false error strobes from correct silence. A single stuck bit at one address must yield errors only on the zero reads that touch it, with the right syndrome and element index. Diagnosis programs are tried in three forms: terminated, unterminated, and overfilled. These three separate end detection, default-end slots and overflow protection. Burn-in on an erased array must give errors only in its zero passes, which checks the pass order and the wrap.

// File: rtl/flash_march_pkg.sv
package flash_march_pkg;

    localparam int CMD_W = 5;
    localparam logic [CMD_W-1:0] CMD_END = 5'b11111;

    typedef enum logic [1:0] {
        K_READ  = 2'd0,
        K_PROG  = 2'd1,
        K_ERASE = 2'd2
    } op_kind_e;

    typedef struct packed {
        logic       is_end;
        logic       is_erase;
        logic [2:0] n_ops;
        logic       up;
    } elem_dec_t;

    typedef struct packed {
        op_kind_e kind;
        logic     exp_one;
    } step_t;

    function automatic elem_dec_t decode_elem(input logic [CMD_W-1:0] c);
        elem_dec_t d;
        d.is_end   = (c[4:2] == 3'b111);
        d.is_erase = (c[4:2] == 3'b100);
        d.up       = c[0];
        case (c[4:2])
            3'b000:  d.n_ops = 3'd1;
            3'b001:  d.n_ops = 3'd2;
            3'b010:  d.n_ops = 3'd3;
            3'b011:  d.n_ops = 3'd4;
            3'b101:  d.n_ops = 3'd2;
            default: d.n_ops = 3'd1;
        endcase
        return d;
    endfunction

    function automatic step_t step_of(input logic [CMD_W-1:0] c, input logic [1:0] s);
        step_t t;
        t.exp_one = 1'b0;
        t.kind    = K_READ;
        case (c[4:2])
            3'b100: t.kind = K_ERASE;
            3'b110: t.kind = K_PROG;
            3'b101: t.kind = (s == 2'd0) ? K_PROG : K_READ;
            default: begin
                if (s == 2'd0) begin
                    t.kind    = K_READ;
                    t.exp_one = c[1];
                end else if (s == 2'd1) begin
                    t.kind = K_PROG;
                end else begin
                    t.kind = K_READ;
                end
            end
        endcase
        return t;
    endfunction

    function automatic logic [CMD_W-1:0] test_rom_cmd(input logic [2:0] i);
        case (i)
            3'd0:    return 5'b10011;
            3'd1:    return 5'b01011;
            3'd2:    return 5'b00001;
            3'd3:    return 5'b10011;
            3'd4:    return 5'b01010;
            3'd5:    return 5'b00000;
            default: return CMD_END;
        endcase
    endfunction

    function automatic logic [CMD_W-1:0] burn_cmd(input logic [2:0] i);
        case (i)
            3'd0:    return 5'b00011;
            3'd1:    return 5'b00001;
            3'd2:    return 5'b00010;
            3'd3:    return 5'b00000;
            3'd4:    return 5'b00011;
            3'd5:    return 5'b00000;
            3'd6:    return 5'b00010;
            default: return 5'b00001;
        endcase
    endfunction

endpackage

// File: rtl/fm_cmd_buffer.sv
module fm_cmd_buffer
    import flash_march_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int IW    = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_en_i,
    input  logic             shift_bit_i,
    input  logic [IW-1:0]    rd_idx_i,
    output logic [CMD_W-1:0] rd_cmd_o
);
    localparam int SW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int PW = $clog2(DEPTH + 1);

    logic [CMD_W-1:0] slots [DEPTH];
    logic [3:0]       sh_q;
    logic [2:0]       cnt_q;
    logic [PW-1:0]    wptr_q;
    logic             full;

    assign full = (wptr_q == PW'(DEPTH));

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            cnt_q  <= '0;
            wptr_q <= '0;
            for (int i = 0; i < DEPTH; i++) slots[i] <= CMD_END;
        end else if (shift_en_i) begin
            sh_q <= {sh_q[2:0], shift_bit_i};
            if (cnt_q == 3'd4) begin
                cnt_q <= '0;
                if (!full) begin
                    slots[wptr_q[SW-1:0]] <= {sh_q, shift_bit_i};
                    wptr_q                <= wptr_q + 1'b1;
                end
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        if (rd_idx_i < IW'(DEPTH)) rd_cmd_o = slots[rd_idx_i[SW-1:0]];
        else                       rd_cmd_o = CMD_END;
    end

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
        wptr_q <= PW'(DEPTH));

    p_full_frozen_r8: assert property (@(posedge clk) disable iff (rst)
        full |=> full && $stable(wptr_q));

endmodule

// File: rtl/fm_elem_source.sv
module fm_elem_source
    import flash_march_pkg::*;
#(
    parameter int IW = 5
) (
    input  logic [1:0]       mode_i,
    input  logic [IW-1:0]    idx_i,
    input  logic [CMD_W-1:0] buf_cmd_i,
    output logic [CMD_W-1:0] cmd_o
);
    logic in_rom;
    assign in_rom = (idx_i < IW'(8));

    always_comb begin
        case (mode_i)
            2'd1:    cmd_o = buf_cmd_i;
            2'd2:    cmd_o = burn_cmd(idx_i[2:0]);
            default: cmd_o = in_rom ? test_rom_cmd(idx_i[2:0]) : CMD_END;
        endcase
    end

    always_comb begin
        if (mode_i == 2'd2) p_burn_no_end_r9: assert (cmd_o[4:2] == 3'b000);
    end

endmodule

// File: rtl/flash_march_seq.sv
module flash_march_seq
    import flash_march_pkg::*;
#(
    parameter int AW    = 6,
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    parameter int IW    = $clog2((DEPTH > 8) ? DEPTH : 8) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run_en_i,
    input  logic [1:0]    mode_i,
    input  logic          shift_en_i,
    input  logic          shift_bit_i,
    output logic          op_req_o,
    output logic [1:0]    op_kind_o,
    output logic [AW-1:0] op_addr_o,
    input  logic          op_rdy_i,
    input  logic [DW-1:0] rd_data_i,
    output logic          err_o,
    output logic [AW-1:0] err_addr_o,
    output logic [DW-1:0] err_syn_o,
    output logic [IW-1:0] err_elem_o,
    output logic          done_o
);
    localparam logic [AW-1:0] ADDR_TOP = {AW{1'b1}};

    typedef enum logic [2:0] {S_IDLE, S_FETCH, S_ISSUE, S_ADV, S_DONE} st_e;

    st_e              st_q;
    logic [1:0]       mode_q;
    logic [IW-1:0]    idx_q;
    logic [CMD_W-1:0] cmd_q;
    logic [1:0]       step_q;
    logic [AW-1:0]    addr_q;
    logic             done_q;

    logic [CMD_W-1:0] buf_cmd, src_cmd;
    elem_dec_t        fdec, cdec;
    step_t            cur;
    logic [DW-1:0]    expect_v, syn;
    logic             last_addr, more_steps;

    fm_cmd_buffer #(.DEPTH(DEPTH), .IW(IW)) u_buf (
        .clk        (clk),
        .rst        (rst),
        .shift_en_i (shift_en_i),
        .shift_bit_i(shift_bit_i),
        .rd_idx_i   (idx_q),
        .rd_cmd_o   (buf_cmd)
    );

    fm_elem_source #(.IW(IW)) u_src (
        .mode_i   (mode_q),
        .idx_i    (idx_q),
        .buf_cmd_i(buf_cmd),
        .cmd_o    (src_cmd)
    );

    assign fdec       = decode_elem(src_cmd);
    assign cdec       = decode_elem(cmd_q);
    assign cur        = step_of(cmd_q, step_q);
    assign expect_v   = {DW{cur.exp_one}};
    assign syn        = rd_data_i ^ expect_v;
    assign last_addr  = cdec.up ? (addr_q == ADDR_TOP) : (addr_q == '0);
    assign more_steps = ({1'b0, step_q} + 3'd1) < cdec.n_ops;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= S_IDLE;
            mode_q     <= '0;
            idx_q      <= '0;
            cmd_q      <= CMD_END;
            step_q     <= '0;
            addr_q     <= '0;
            done_q     <= 1'b0;
            err_o      <= 1'b0;
            err_addr_o <= '0;
            err_syn_o  <= '0;
            err_elem_o <= '0;
        end else begin
            err_o <= 1'b0;
            if (!run_en_i) begin
                st_q   <= S_IDLE;
                done_q <= 1'b0;
                idx_q  <= '0;
            end else begin
                case (st_q)
                    S_IDLE: begin
                        mode_q <= mode_i;
                        idx_q  <= '0;
                        st_q   <= S_FETCH;
                    end
                    S_FETCH: begin
                        if (fdec.is_end) begin
                            done_q <= 1'b1;
                            st_q   <= S_DONE;
                        end else begin
                            cmd_q  <= src_cmd;
                            step_q <= '0;
                            addr_q <= (fdec.is_erase || fdec.up) ? '0 : ADDR_TOP;
                            st_q   <= S_ISSUE;
                        end
                    end
                    S_ISSUE: begin
                        if (op_rdy_i) begin
                            if (cur.kind == K_READ && syn != '0) begin
                                err_o      <= 1'b1;
                                err_addr_o <= addr_q;
                                err_syn_o  <= syn;
                                err_elem_o <= idx_q;
                            end
                            st_q <= S_ADV;
                        end
                    end
                    S_ADV: begin
                        if (!cdec.is_erase && more_steps) begin
                            step_q <= step_q + 1'b1;
                            st_q   <= S_ISSUE;
                        end else if (!cdec.is_erase && !last_addr) begin
                            addr_q <= cdec.up ? addr_q + 1'b1 : addr_q - 1'b1;
                            step_q <= '0;
                            st_q   <= S_ISSUE;
                        end else begin
                            if (mode_q == 2'd2 && idx_q[2:0] == 3'd7) begin
                                idx_q  <= '0;
                                done_q <= 1'b1;
                            end else begin
                                idx_q <= idx_q + 1'b1;
                            end
                            st_q <= S_FETCH;
                        end
                    end
                    default: st_q <= S_DONE;
                endcase
            end
        end
    end

    assign op_req_o  = (st_q == S_ISSUE);
    assign op_kind_o = cur.kind;
    assign op_addr_o = cdec.is_erase ? '0 : addr_q;
    assign done_o    = done_q;

    p_req_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (op_req_o && !op_rdy_i && run_en_i) |=> op_req_o);

    p_req_stable_r10: assert property (@(posedge clk) disable iff (rst)
        (op_req_o && !op_rdy_i && run_en_i) |=> ($stable(op_addr_o) && $stable(op_kind_o)));

    p_req_drop_r10: assert property (@(posedge clk) disable iff (rst)
        (op_req_o && op_rdy_i) |=> !op_req_o);

    p_err_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        err_o |=> !err_o);

    p_err_after_read_r4: assert property (@(posedge clk) disable iff (rst)
        err_o |-> $past(op_req_o && op_rdy_i && op_kind_o == 2'd0));

    p_erase_addr_r5: assert property (@(posedge clk) disable iff (rst)
        (op_req_o && op_kind_o == 2'd2) |-> (op_addr_o == '0));

    p_abort_idle_r11: assert property (@(posedge clk) disable iff (rst)
        !run_en_i |=> (!op_req_o && !done_o));

endmodule

// File: tb/flash_march_seq_tb.sv
`timescale 1ns/1ps
module flash_march_seq_tb_top;
    localparam int AW = 3, DW = 8, DEPTH = 4, LAT = 2, NW = 8;
    localparam int IW = $clog2(8) + 1;

    logic clk = 1'b0, rst = 1'b1, run_en = 1'b0, shift_en = 1'b0, shift_bit = 1'b0;
    logic [1:0] mode = 2'd0;
    logic op_req, op_rdy, err, done;
    logic [1:0] op_kind;
    logic [AW-1:0] op_addr, err_addr;
    logic [DW-1:0] rd_data, err_syn;
    logic [IW-1:0] err_elem;

    flash_march_seq #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .IW(IW)) dut_i (
        .clk(clk), .rst(rst), .run_en_i(run_en), .mode_i(mode),
        .shift_en_i(shift_en), .shift_bit_i(shift_bit),
        .op_req_o(op_req), .op_kind_o(op_kind), .op_addr_o(op_addr),
        .op_rdy_i(op_rdy), .rd_data_i(rd_data),
        .err_o(err), .err_addr_o(err_addr), .err_syn_o(err_syn),
        .err_elem_o(err_elem), .done_o(done)
    );

    always #2.5 clk = ~clk;

    int n_checks = 0, n_fail = 0, cyc = 0;
    logic [DW-1:0] mem [NW];
    int log_k [512], log_a [512], log_n;
    int exp_k [512], exp_a [512], exp_n;
    int cnt, err_n, e_addr, e_syn, e_elem, viol;
    logic fault_en = 1'b0;
    int fault_addr = 5;
    logic [DW-1:0] fault_mask = 8'h04;
    logic p_req, p_rdy, p_run;
    logic [1:0] p_kind;
    logic [AW-1:0] p_addr;

    assign rd_data = mem[op_addr];

    // flash model: ready LAT+1 cycles after request seen
    always @(posedge clk) begin
        if (rst) begin
            op_rdy <= 1'b0; cnt <= 0; log_n <= 0;
            for (int i = 0; i < NW; i++) mem[i] <= '1;
        end else if (op_rdy) begin
            op_rdy <= 1'b0;
        end else if (op_req) begin
            if (cnt == LAT) begin
                op_rdy <= 1'b1; cnt <= 0;
                log_k[log_n] <= int'(op_kind); log_a[log_n] <= int'(op_addr);
                log_n <= log_n + 1;
                if (op_kind == 2'd2) for (int i = 0; i < NW; i++) mem[i] <= '1;
                if (op_kind == 2'd1)
                    mem[op_addr] <= (fault_en && int'(op_addr) == fault_addr) ? fault_mask : '0;
            end else cnt <= cnt + 1;
        end else cnt <= 0;
    end

    // error logger and handshake monitor, away from the active edge
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (rst) begin
            err_n <= 0; viol <= 0; p_req <= 0; p_rdy <= 0; p_run <= 0;
        end else begin
            if (err) begin
                if (err_n == 0) begin
                    e_addr <= int'(err_addr); e_syn <= int'(err_syn); e_elem <= int'(err_elem);
                end
                err_n <= err_n + 1;
            end
            if (p_req && !p_rdy && p_run && (!op_req || op_kind != p_kind || op_addr != p_addr))
                viol <= viol + 1;
            if (p_rdy && op_req) viol <= viol + 1;
            p_req <= op_req; p_rdy <= op_rdy; p_run <= run_en; p_kind <= op_kind; p_addr <= op_addr;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1; run_en = 0; shift_en = 0; fault_en = 0; mode = 0;
        repeat (3) @(negedge clk);
        rst = 0; exp_n = 0;
        @(negedge clk);
    endtask

    task automatic push(input int k, input int a);
        exp_k[exp_n] = k; exp_a[exp_n] = a; exp_n++;
    endtask

    // expected stream from the command table (R2, R3, R5)
    task automatic add_cmd(input logic [4:0] c);
        int n;
        int a;
        if (c[4:2] == 3'b111) return;
        if (c[4:2] == 3'b100) begin push(2, 0); return; end
        for (int j = 0; j < NW; j++) begin
            a = c[0] ? j : NW - 1 - j;
            case (c[4:2])
                3'b101: begin push(1, a); push(0, a); end
                3'b110: push(1, a);
                default: begin
                    n = int'(c[4:2]) + 1;
                    push(0, a);
                    if (n > 1) push(1, a);
                    if (n > 2) push(0, a);
                    if (n > 3) push(0, a);
                end
            endcase
        end
    endtask

    task automatic cmp_ops(input string req, input int upto);
        int bad;
        bad = 0;
        for (int i = 0; i < upto; i++)
            if (log_k[i] != exp_k[i] || log_a[i] != exp_a[i]) bad++;
        check(bad == 0, req, bad, 0);
    endtask

    task automatic shift_cmd(input logic [4:0] c);
        for (int b = 4; b >= 0; b--) begin
            shift_en = 1; shift_bit = c[b]; @(negedge clk);
        end
        shift_en = 0;
    endtask

    task automatic run_to_done(input logic [1:0] m);
        int t;
        mode = m; run_en = 1; t = 0;
        while (!done && t < 20000) begin @(negedge clk); t++; end
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        check(op_req == 0, "R1 req", int'(op_req), 0);
        check(done == 0, "R1 done", int'(done), 0);
        check(err == 0, "R1 err", int'(err), 0);
    endtask

    task automatic t_test_clean();
        do_reset();
        add_cmd(5'b10011); add_cmd(5'b01011); add_cmd(5'b00001);
        add_cmd(5'b10011); add_cmd(5'b01010); add_cmd(5'b00000);
        run_to_done(2'd0);
        check(log_n == exp_n, "R6 op count", log_n, exp_n);
        cmp_ops("R6 R2 R3 R5 op order", exp_n);
        check(err_n == 0, "R4 clean errors", err_n, 0);
        check(done == 1, "R6 done", int'(done), 1);
        check(viol == 0, "R10 handshake", viol, 0);
        run_en = 0;
    endtask

    task automatic t_test_fault();
        do_reset();
        fault_en = 1;
        run_to_done(2'd0);
        check(err_n == 4, "R4 fault count", err_n, 4);
        check(e_addr == fault_addr, "R4 err addr", e_addr, fault_addr);
        check(e_syn == 4, "R4 syndrome", e_syn, 4);
        check(e_elem == 1, "R4 elem index", e_elem, 1);
        run_en = 0;
    endtask

    task automatic t_diag();
        do_reset();
        shift_cmd(5'b10011); shift_cmd(5'b00111); shift_cmd(5'b01100); shift_cmd(5'b11111);
        add_cmd(5'b10011); add_cmd(5'b00111); add_cmd(5'b01100);
        run_to_done(2'd1);
        check(log_n == exp_n, "R7 op count", log_n, exp_n);
        cmp_ops("R7 R2 R3 diag order", exp_n);
        check(done == 1 && err_n == 0, "R7 done clean", err_n, 0);
        run_en = 0;
    endtask

    task automatic t_diag_unterminated();
        do_reset();
        shift_cmd(5'b10011); shift_cmd(5'b00001);
        run_to_done(2'd1);
        check(log_n == 9, "R8 default end", log_n, 9);
        check(err_n == 8, "R4 r0 on erased", err_n, 8);
        check(e_syn == 255 && e_elem == 1, "R4 syndrome ff", e_syn, 255);
        run_en = 0;
    endtask

    task automatic t_diag_overflow();
        do_reset();
        shift_cmd(5'b10011); shift_cmd(5'b00011); shift_cmd(5'b11000); shift_cmd(5'b00000);
        shift_cmd(5'b10011); shift_cmd(5'b00011);
        add_cmd(5'b10011); add_cmd(5'b00011); add_cmd(5'b11000); add_cmd(5'b00000);
        run_to_done(2'd1);
        check(log_n == exp_n, "R8 overflow ignored", log_n, exp_n);
        cmp_ops("R8 overflow order", exp_n);
        check(err_n == 0, "R8 overflow clean", err_n, 0);
        run_en = 0;
    endtask

    task automatic t_burn();
        int t;
        do_reset();
        add_cmd(5'b00011); add_cmd(5'b00001); add_cmd(5'b00010); add_cmd(5'b00000);
        add_cmd(5'b00011); add_cmd(5'b00000); add_cmd(5'b00010); add_cmd(5'b00001);
        mode = 2'd2; run_en = 1; t = 0;
        while (!done && t < 20000) begin @(negedge clk); t++; end
        check(log_n == 64, "R9 first round count", log_n, 64);
        cmp_ops("R9 pass order", 64);
        check(err_n == 32, "R9 r0 passes fail", err_n, 32);
        t = 0;
        while (log_n < 72 && t < 2000) begin @(negedge clk); t++; end
        check(log_n >= 72 && done == 1, "R9 keeps looping", log_n, 72);
        check(log_a[64] == 0 && log_k[64] == 0, "R9 wrap to up r1", log_a[64], 0);
        run_en = 0;
        @(negedge clk);
        check(op_req == 0 && done == 0, "R11 burn stop", int'(op_req) + int'(done), 0);
    endtask

    task automatic t_abort();
        do_reset();
        mode = 2'd0; run_en = 1;
        repeat (30) @(negedge clk);
        run_en = 0;
        @(negedge clk);
        check(op_req == 0 && done == 0, "R11 abort", int'(op_req), 0);
        check(viol == 0, "R10 handshake abort", viol, 0);
    endtask

    initial begin
        t_reset();
        t_test_clean();
        t_test_fault();
        t_diag();
        t_diag_unterminated();
        t_diag_overflow();
        t_burn();
        t_abort();
        $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
        $finish;
    end

    always @(posedge clk) begin
        if (cyc > 150000) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
            $finish;
        end
    end

endmodule